// File: doc/BRIEF.md
# Multiprocessor Core Launch and Hold Controller

This block sits on a simple register bus inside an N-core cluster and decides which cores are allowed to run. Firmware on the boot core first programs an entry point and an initial stack pointer, then names a secondary core by index. That core receives the two values on its own start-PC and start-SP outputs, its run enable rises, and a single-cycle start strobe tells the core to take the values in. The same bus can stop every core but one, for example around a critical update, and can bring one core back afterwards.

Each bus access carries an address, a write enable, 64-bit write data, a size code and the index of the core making the access. Two read-only registers report the caller's own index and the cluster size. The block only presents the launch values and the strobe. Copying them into a core's register file is left to the core.

Top module: `mpc_top`

## Requirements
- R1: During and right after reset, core 0's run enable is 1, every other run enable is 0, no start strobe is high, and every start-PC and start-SP output is 0.
- R2: After reset, and until software writes them, the stored entry point and stack pointer equal the parameters RST_PC and RST_SP. A start issued right after reset delivers exactly these values.
- R3: A write of index k < NUM_CORES to the launch register (offset 0x10) loads core k's start-PC and start-SP from the stored values and sets its run enable. Both changes appear after the clock edge that accepts the write. Core k's start strobe is high for exactly that one following cycle, and no other strobe rises.
- R4: A launch write whose index is NUM_CORES or larger changes nothing. No strobe rises, and the run enables and the start-PC and start-SP outputs keep their values.
- R5: Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A write to the entry-point register (0x18) or the stack register (0x20) with size code 2, bits 63:32 zero and bit 31 set stores the value with bits 63:32 set to ones. Every other write to these registers stores the data unchanged.
- R6: A write of index k to the hold register (0x28) clears the run enable of every core other than k and leaves core k's enable as it was. An index of NUM_CORES or larger therefore clears all enables.
- R7: A write of index k to the resume register (0x30) sets core k's run enable only when k < NUM_CORES. Other cores are untouched, and an out-of-range index has no effect.
- R8: Reads are combinational. Offset 0x00 returns the requesting core's index, zero-extended. Offset 0x08 returns NUM_CORES. Every other offset, including the write-only registers, returns 0.
- R9: An entry-point or stack write accepted in one cycle is used by a launch write accepted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write enable for the current access |
| bus_addr | input | 6 | Byte offset of the register |
| bus_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| bus_src_core | input | CORE_W | Index of the core making the access |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, combinational from address |
| core_run | output | NUM_CORES | Run enable for each core |
| core_start | output | NUM_CORES | One-cycle launch strobe for each core |
| core_pc | output | NUM_CORES*64 | Start PC for each core, core i at bits [64*i +: 64] |
| core_sp | output | NUM_CORES*64 | Start SP for each core, core i at bits [64*i +: 64] |

## Verification
Two things can overlap in one cycle. The first is a launch strobe that is still high while the next bus write is a hold command. The second is a stored-address update that is followed at once by the launch that consumes it. The bench issues a launch and then a hold on the very next cycle. It checks that the strobe shows exactly one cycle for the launched core and that the hold then leaves only the named core running. It also writes the entry point and launches on the following cycle, and checks that the launched core sees the new value and not the old one.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int DW     = 64;
    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFF_SELF_ID = 6'h00,
        OFF_N_CORES = 6'h08,
        OFF_LAUNCH  = 6'h10,
        OFF_ENTRY   = 6'h18,
        OFF_STACK   = 6'h20,
        OFF_HOLD    = 6'h28,
        OFF_RESUME  = 6'h30
    } reg_off_e;

    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef struct packed {
        logic          launch;
        logic          set_entry;
        logic          set_stack;
        logic          hold;
        logic          resume;
        logic [1:0]    size;
        logic [DW-1:0] val;
    } bus_cmd_t;

    // A 4-byte write of a value with bit 31 set and a clear upper half
    // is taken as a negative 32-bit address and widened.
    function automatic logic [DW-1:0] widen_addr(input logic [DW-1:0] v,
                                                 input logic [1:0] sz);
        if (sz == SZ_WORD && v[63:32] == 32'h0 && v[31])
            return {32'hFFFF_FFFF, v[31:0]};
        return v;
    endfunction

endpackage

// File: rtl/mpc_wr_decode.sv
module mpc_wr_decode
    import mpc_pkg::*;
(
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DW-1:0]     wr_data,
    output bus_cmd_t          cmd
);
    always_comb begin
        cmd.launch    = bus_wr && (bus_addr == OFF_LAUNCH);
        cmd.set_entry = bus_wr && (bus_addr == OFF_ENTRY);
        cmd.set_stack = bus_wr && (bus_addr == OFF_STACK);
        cmd.hold      = bus_wr && (bus_addr == OFF_HOLD);
        cmd.resume    = bus_wr && (bus_addr == OFF_RESUME);
        cmd.size      = bus_size;
        cmd.val       = wr_data;
    end
endmodule

// File: rtl/mpc_addr_store.sv
module mpc_addr_store
    import mpc_pkg::*;
#(
    parameter logic [DW-1:0] RST_PC = 64'hFFFF_FFFF_BFC0_0000,
    parameter logic [DW-1:0] RST_SP = 64'hFFFF_FFFF_A000_7F00
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_cmd_t      cmd,
    output logic [DW-1:0] entry_q,
    output logic [DW-1:0] stack_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= RST_PC;
            stack_q <= RST_SP;
        end else begin
            if (cmd.set_entry) entry_q <= widen_addr(cmd.val, cmd.size);
            if (cmd.set_stack) stack_q <= widen_addr(cmd.val, cmd.size);
        end
    end
endmodule

// File: rtl/mpc_core_slot.sv
module mpc_core_slot
    import mpc_pkg::*;
#(
    parameter int   IDX      = 0,
    parameter logic RUN_INIT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_cmd_t      cmd,
    input  logic [DW-1:0] entry_q,
    input  logic [DW-1:0] stack_q,
    output logic          run,
    output logic          start,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] sp
);
    // The full 64-bit compare makes every out-of-range index miss all slots.
    logic hit;
    assign hit = (cmd.val == DW'(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= RUN_INIT;
            start <= 1'b0;
            pc    <= '0;
            sp    <= '0;
        end else begin
            start <= cmd.launch && hit;
            if (cmd.launch && hit) begin
                pc  <= entry_q;
                sp  <= stack_q;
                run <= 1'b1;
            end else if (cmd.resume && hit) begin
                run <= 1'b1;
            end else if (cmd.hold && !hit) begin
                run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpc_top.sv
module mpc_top
    import mpc_pkg::*;
#(
    parameter int            NUM_CORES = 4,
    parameter int            CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter logic [63:0]   RST_PC    = 64'hFFFF_FFFF_BFC0_0000,
    parameter logic [63:0]   RST_SP    = 64'hFFFF_FFFF_A000_7F00
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [5:0]               bus_addr,
    input  logic [1:0]               bus_size,
    input  logic [CORE_W-1:0]        bus_src_core,
    input  logic [63:0]              wr_data,
    output logic [63:0]              rd_data,
    output logic [NUM_CORES-1:0]     core_run,
    output logic [NUM_CORES-1:0]     core_start,
    output logic [NUM_CORES*64-1:0]  core_pc,
    output logic [NUM_CORES*64-1:0]  core_sp
);
    bus_cmd_t      cmd;
    logic [DW-1:0] entry_q;
    logic [DW-1:0] stack_q;

    mpc_wr_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .wr_data  (wr_data),
        .cmd      (cmd)
    );

    mpc_addr_store #(.RST_PC(RST_PC), .RST_SP(RST_SP)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .entry_q (entry_q),
        .stack_q (stack_q)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        mpc_core_slot #(.IDX(i), .RUN_INIT(i == 0)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd),
            .entry_q (entry_q),
            .stack_q (stack_q),
            .run     (core_run[i]),
            .start   (core_start[i]),
            .pc      (core_pc[DW*i +: DW]),
            .sp      (core_sp[DW*i +: DW])
        );
    end

    always_comb begin
        case (bus_addr)
            OFF_SELF_ID: rd_data = DW'(bus_src_core);
            OFF_N_CORES: rd_data = DW'(NUM_CORES);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [5:0]           bus_addr,
    input logic [CORE_W-1:0]    bus_src_core,
    input logic [63:0]          wr_data,
    input logic [63:0]          rd_data,
    input logic [NUM_CORES-1:0] core_run,
    input logic [NUM_CORES-1:0] core_start
);
    logic in_range;
    assign in_range = (wr_data < 64'(NUM_CORES));

    assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h10 && in_range) |=> ($countones(core_start) == 1));

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_start));

    assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (core_start != '0) |-> $past(bus_wr && bus_addr == 6'h10));

    assert_launch_oor_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h10 && !in_range) |=> (core_start == '0 && $stable(core_run)));

    assert_hold_all_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h28 && !in_range) |=> (core_run == '0));

    assert_resume_oor_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h30 && !in_range) |=> $stable(core_run));

    assert_self_id_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 6'h00) |-> (rd_data == 64'(bus_src_core)));
endmodule

bind mpc_top mpc_checker #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_mpc_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_src_core (bus_src_core),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .core_run     (core_run),
    .core_start   (core_start)
);

// File: tb/test_mpc_top.sv
module test_mpc_top;
    localparam int          N      = 4;
    localparam int          CW     = 2;
    localparam logic [63:0] RST_PC = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [63:0] RST_SP = 64'hFFFF_FFFF_A000_7F00;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [1:0]      bus_size = 2'd3;
    logic [CW-1:0]   bus_src_core = '0;
    logic [63:0]     wr_data = '0;
    logic [63:0]     rd_data;
    logic [N-1:0]    core_run;
    logic [N-1:0]    core_start;
    logic [N*64-1:0] core_pc;
    logic [N*64-1:0] core_sp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mpc_top #(.NUM_CORES(N), .CORE_W(CW), .RST_PC(RST_PC), .RST_SP(RST_SP)) i_mpc_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_src_core(bus_src_core), .wr_data(wr_data),
        .rd_data(rd_data), .core_run(core_run), .core_start(core_start),
        .core_pc(core_pc), .core_sp(core_sp)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; presents one write for one cycle, returns at the next negedge.
    task automatic wr(input logic [5:0] a, input logic [63:0] d, input logic [1:0] s);
        bus_addr = a; wr_data = d; bus_size = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h38; wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 run", 64'(core_run), 64'h1);
        chk("R1 strobe", 64'(core_start), 64'h0);
        chk("R1 pc1", core_pc[64 +: 64], 64'h0);
        chk("R1 sp3", core_sp[192 +: 64], 64'h0);
    endtask

    task automatic t_launch_defaults;
        wr(6'h10, 64'd1, 2'd3);
        chk("R2 pc1", core_pc[64 +: 64], RST_PC);
        chk("R2 sp1", core_sp[64 +: 64], RST_SP);
        chk("R3 run", 64'(core_run), 64'h3);
        chk("R3 strobe", 64'(core_start), 64'h2);
        @(negedge clk);
        chk("R3 strobe one cycle", 64'(core_start), 64'h0);
    endtask

    task automatic t_widen;
        wr(6'h18, 64'h0000_0000_8000_1000, 2'd2);
        wr(6'h20, 64'h0000_0000_8000_2000, 2'd3);
        wr(6'h10, 64'd2, 2'd3);
        chk("R5 pc2 widened", core_pc[128 +: 64], 64'hFFFF_FFFF_8000_1000);
        chk("R5 sp2 8-byte kept", core_sp[128 +: 64], 64'h0000_0000_8000_2000);
        // R9: entry written, launch on the very next cycle
        wr(6'h18, 64'h0000_0000_7000_0000, 2'd2);
        wr(6'h10, 64'd3, 2'd3);
        chk("R9 pc3 fresh", core_pc[192 +: 64], 64'h0000_0000_7000_0000);
        chk("R3 run all", 64'(core_run), 64'hF);
    endtask

    task automatic t_launch_oor;
        wr(6'h10, 64'd4, 2'd3);
        chk("R4 no strobe", 64'(core_start), 64'h0);
        chk("R4 run kept", 64'(core_run), 64'hF);
        chk("R4 pc0 kept", core_pc[0 +: 64], 64'h0);
        wr(6'h10, 64'h1_0000_0001, 2'd3);
        chk("R4 wide idx no strobe", 64'(core_start), 64'h0);
        chk("R4 pc1 kept", core_pc[64 +: 64], RST_PC);
    endtask

    task automatic t_hold_resume;
        wr(6'h28, 64'd2, 2'd3);
        chk("R6 hold keeps 2", 64'(core_run), 64'h4);
        wr(6'h28, 64'd1, 2'd3);
        chk("R6 named core not set", 64'(core_run), 64'h0);
        wr(6'h30, 64'd0, 2'd3);
        chk("R7 resume 0", 64'(core_run), 64'h1);
        wr(6'h30, 64'd4, 2'd3);
        chk("R7 resume oor", 64'(core_run), 64'h1);
        wr(6'h30, 64'd3, 2'd3);
        chk("R7 resume 3", 64'(core_run), 64'h9);
        wr(6'h28, 64'd9, 2'd3);
        chk("R6 hold oor clears all", 64'(core_run), 64'h0);
        wr(6'h30, 64'd0, 2'd3);
        wr(6'h30, 64'd3, 2'd3);
    endtask

    task automatic t_reads;
        bus_addr = 6'h00; bus_src_core = 2'd2; #1;
        chk("R8 self id 2", rd_data, 64'd2);
        bus_src_core = 2'd3; #1;
        chk("R8 self id 3", rd_data, 64'd3);
        bus_addr = 6'h08; #1;
        chk("R8 core count", rd_data, 64'd4);
        bus_addr = 6'h18; #1;
        chk("R8 entry reads 0", rd_data, 64'd0);
        bus_addr = 6'h30; #1;
        chk("R8 resume reads 0", rd_data, 64'd0);
        @(negedge clk);
    endtask

    task automatic t_overlap;
        wr(6'h10, 64'd1, 2'd3);
        chk("R3 strobe before hold", 64'(core_start), 64'h2);
        chk("R3 run with 1", 64'(core_run), 64'hB);
        wr(6'h28, 64'd3, 2'd3);
        chk("R3 strobe gone", 64'(core_start), 64'h0);
        chk("R6 hold after launch", 64'(core_run), 64'h8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_launch_defaults();
        t_widen();
        t_launch_oor();
        t_hold_resume();
        t_reads();
        t_overlap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule